// File: doc/BRIEF.md
# Four-Way Translation Lookaside Buffer with Store Protection

This block keeps recently used page mappings close to the pipeline and turns a 32-bit virtual address into a 30-bit physical address. A lookup strobe comes with the address and a store flag. One cycle later the block reports exactly one outcome:
- a hit, with the translated address;
- a translation miss;
- a store-protection fault, raised when a store hits an entry whose store-permit bit is clear.

On a miss or a fault the physical address output is zero.

Mappings are installed through a refill port, normally driven by a page table walker. The port carries a virtual page number, a physical page number and a store-permit bit. The storage is 64 entries, organised as 16 sets of 4 ways. Each set has a 3-bit tree pseudo-LRU state that picks the way to replace. A flush input invalidates every entry in a single cycle.

Top module: `xlat_tlb`

## Requirements
- R1: When `lk_valid` is high and a valid entry in the indexed set has a matching tag, and either `lk_write` is low or the entry's store-permit bit is set, then on the next cycle `rsp_hit` is 1 and `rsp_paddr` equals {stored 18-bit physical page, `lk_vaddr[11:0]`}.
- R2: A lookup that finds no valid entry with a matching tag gives `rsp_miss`=1, `rsp_hit`=0 and `rsp_paddr`=0 on the next cycle.
- R3: A lookup with `lk_write`=1 that matches an entry whose store-permit bit is 0 gives `rsp_wprot`=1, `rsp_hit`=0 and `rsp_paddr`=0 on the next cycle. A lookup with `lk_write`=0 to the same entry hits.
- R4: At most one of `rsp_hit`, `rsp_miss` and `rsp_wprot` is high in any cycle. Exactly one is high in the cycle after a strobe. In every other cycle all three are low and `rsp_paddr` is 0.
- R5: The set is chosen by virtual page bits [3:0] (address bits [15:12]). The tag is virtual page bits [19:4] (address bits [31:16]). Pages that share a set but differ in tag never alias.
- R6: A refill first overwrites a valid entry in the set that has the same tag. Failing that, it uses the lowest-numbered invalid way. Failing that, it uses the pseudo-LRU victim.
- R7: Each set has pseudo-LRU bits p[2:0]:
  - p[0]=0 selects ways 0/1 as the victim half, and p[0]=1 selects ways 2/3.
  - p[1] picks within ways 0/1 (0 means way 0).
  - p[2] picks within ways 2/3 (0 means way 2).
  - Using way w sets p[0] to point at the other half and sets the bit of w's half to point at w's sibling.
  - Every lookup tag match and every refill counts as a use.
  - If a refill and a lookup match fall in the same set in the same cycle, only the refill updates the bits.
  - All bits are 0 after reset.
- R8: `flush` invalidates all 64 entries in one cycle. A refill presented in the same cycle as a flush is discarded.
- R9: A lookup sees the contents held before any refill or flush presented in the same cycle.
- R10: After reset every entry is invalid and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Lookup is a store |
| fill_en | input | 1 | Install a mapping |
| fill_vpn | input | 20 | Virtual page number of the mapping |
| fill_ppn | input | 18 | Physical page number of the mapping |
| fill_wr_ok | input | 1 | Store-permit bit of the mapping |
| flush | input | 1 | Invalidate every entry |
| rsp_hit | output | 1 | Translation valid |
| rsp_miss | output | 1 | Translation miss exception |
| rsp_wprot | output | 1 | Store-protection exception |
| rsp_paddr | output | 30 | Physical address, zero unless hit |

## Verification
The bound checker watches the cycle-level rules on every cycle:
- the outcome flags are exclusive, and exactly one of them answers each strobe;
- the address is zero unless there is a hit, and the offset passes through unchanged on a hit;
- loads never fault;
- a lookup right after a flush always misses.

Which entry a refill lands in, and the pseudo-LRU victim sequence, cannot be seen in a single cycle. The bench shows them by running directed eviction scenarios and long random mixes of refills, lookups and flushes against its own model of the tag, permission and pseudo-LRU state.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    parameter int VA_W   = 32;
    parameter int OFF_W  = 12;
    parameter int VPN_W  = VA_W - OFF_W;
    parameter int PPN_W  = 18;
    parameter int PA_W   = PPN_W + OFF_W;
    parameter int WAYS   = 4;
    parameter int SETS   = 16;

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int WAY_W = $clog2(WAYS);
    localparam int PLRU_W = WAYS - 1;

    typedef logic [IDX_W-1:0]  set_idx_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [PLRU_W-1:0] plru_t;

    typedef struct packed {
        logic             vld;
        tag_t             tag;
        logic [PPN_W-1:0] ppn;
        logic             wr_ok;
    } tlb_entry_t;

    typedef tlb_entry_t [WAYS-1:0] tlb_row_t;

    // Victim pointed to by the tree bits.
    function automatic way_t plru_victim(plru_t p);
        way_t v;
        if (p[0]) v = p[2] ? way_t'(3) : way_t'(2);
        else      v = p[1] ? way_t'(1) : way_t'(0);
        return v;
    endfunction

    // Steer the tree away from the way just used.
    function automatic plru_t plru_touch(plru_t p, way_t w);
        plru_t r;
        r = p;
        if (!w[1]) begin
            r[0] = 1'b1;
            r[1] = ~w[0];
        end else begin
            r[0] = 1'b0;
            r[2] = ~w[0];
        end
        return r;
    endfunction

    // Lowest-numbered way whose valid bit is clear.
    function automatic way_t first_free(logic [WAYS-1:0] vld);
        way_t w;
        w = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!vld[i]) w = way_t'(i);
        end
        return w;
    endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
(
    input  tlb_row_t row,
    input  tag_t     tag,
    output logic     any_hit,
    output way_t     hit_way,
    output logic [WAYS-1:0] vld_vec
);
    logic [WAYS-1:0] hit_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_vec[w] = row[w].vld && (row[w].tag == tag);
        assign vld_vec[w] = row[w].vld;
    end

    always_comb begin
        hit_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_way = way_t'(i);
        end
    end

    assign any_hit = |hit_vec;

endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       wr_en,
    input  set_idx_t   wr_set,
    input  way_t       wr_way,
    input  tlb_entry_t wr_ent,
    input  set_idx_t   rd_set_a,
    input  set_idx_t   rd_set_b,
    output tlb_row_t   row_a,
    output tlb_row_t   row_b
);
    tlb_row_t mem_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) mem_q[s] <= '0;
        end else if (flush) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) mem_q[s][w].vld <= 1'b0;
            end
        end else if (wr_en) begin
            mem_q[wr_set][wr_way] <= wr_ent;
        end
    end

    assign row_a = mem_q[rd_set_a];
    assign row_b = mem_q[rd_set_b];

endmodule

// File: rtl/tlb_plru.sv
module tlb_plru
    import tlb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hit_en,
    input  set_idx_t hit_set,
    input  way_t     hit_way,
    input  logic     fill_en,
    input  set_idx_t fill_set,
    input  way_t     fill_way,
    output plru_t    fill_bits
);
    plru_t bits_all [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        plru_t bits_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bits_q <= '0;
            end else if (fill_en && fill_set == set_idx_t'(s)) begin
                bits_q <= plru_touch(bits_q, fill_way);
            end else if (hit_en && hit_set == set_idx_t'(s)) begin
                bits_q <= plru_touch(bits_q, hit_way);
            end
        end
        assign bits_all[s] = bits_q;
    end

    assign fill_bits = bits_all[fill_set];

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             lk_write,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_wr_ok,
    input  logic             flush,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_wprot,
    output logic [PA_W-1:0]  rsp_paddr
);
    // Address split
    set_idx_t lk_set, fl_set;
    tag_t     lk_tag, fl_tag;
    assign lk_set = lk_vaddr[OFF_W +: IDX_W];
    assign lk_tag = lk_vaddr[OFF_W + IDX_W +: TAG_W];
    assign fl_set = fill_vpn[IDX_W-1:0];
    assign fl_tag = fill_vpn[VPN_W-1:IDX_W];

    tlb_row_t        lk_row, fl_row;
    logic            lk_any, fl_any;
    way_t            lk_way, fl_match_way, fl_way;
    logic [WAYS-1:0] lk_vld, fl_vld;
    plru_t           fl_bits;
    logic            fill_do, lk_touch;
    tlb_entry_t      new_ent, lk_ent;

    assign fill_do  = fill_en && !flush;
    assign lk_touch = lk_valid && lk_any;

    tlb_store u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .wr_en    (fill_do),
        .wr_set   (fl_set),
        .wr_way   (fl_way),
        .wr_ent   (new_ent),
        .rd_set_a (lk_set),
        .rd_set_b (fl_set),
        .row_a    (lk_row),
        .row_b    (fl_row)
    );

    tlb_match u_lk_match (
        .row     (lk_row),
        .tag     (lk_tag),
        .any_hit (lk_any),
        .hit_way (lk_way),
        .vld_vec (lk_vld)
    );

    tlb_match u_fl_match (
        .row     (fl_row),
        .tag     (fl_tag),
        .any_hit (fl_any),
        .hit_way (fl_match_way),
        .vld_vec (fl_vld)
    );

    tlb_plru u_plru (
        .clk       (clk),
        .rst       (rst),
        .hit_en    (lk_touch),
        .hit_set   (lk_set),
        .hit_way   (lk_way),
        .fill_en   (fill_do),
        .fill_set  (fl_set),
        .fill_way  (fl_way),
        .fill_bits (fl_bits)
    );

    // Placement: same tag, then a free way, then the tree victim.
    always_comb begin
        if (fl_any)         fl_way = fl_match_way;
        else if (&fl_vld)   fl_way = plru_victim(fl_bits);
        else                fl_way = first_free(fl_vld);
    end

    always_comb begin
        new_ent.vld   = 1'b1;
        new_ent.tag   = fl_tag;
        new_ent.ppn   = fill_ppn;
        new_ent.wr_ok = fill_wr_ok;
    end

    assign lk_ent = lk_row[lk_way];

    logic unused_vld;
    assign unused_vld = ^lk_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_wprot <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_hit   <= lk_touch && (!lk_write || lk_ent.wr_ok);
            rsp_wprot <= lk_touch && lk_write && !lk_ent.wr_ok;
            rsp_miss  <= lk_valid && !lk_any;
            if (lk_touch && (!lk_write || lk_ent.wr_ok))
                rsp_paddr <= {lk_ent.ppn, lk_vaddr[OFF_W-1:0]};
            else
                rsp_paddr <= '0;
        end
    end

endmodule

// File: rtl/tlb_chk.sv
module tlb_chk
    import tlb_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            lk_valid,
    input logic            lk_write,
    input logic [VA_W-1:0] lk_vaddr,
    input logic            flush,
    input logic            rsp_hit,
    input logic            rsp_miss,
    input logic            rsp_wprot,
    input logic [PA_W-1:0] rsp_paddr
);
    // R4
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_hit, rsp_miss, rsp_wprot}));

    // R4
    one_answer_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> $countones({rsp_hit, rsp_miss, rsp_wprot}) == 1);

    // R4
    no_unasked_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !(rsp_hit || rsp_miss || rsp_wprot));

    // R2
    addr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> rsp_paddr == '0);

    // R1
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> (!rsp_hit || rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

    // R3
    load_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !lk_write) |=> !rsp_wprot);

    // R8
    flush_miss_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(flush) && lk_valid) |=> rsp_miss);

endmodule

bind xlat_tlb tlb_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .lk_write  (lk_write),
    .lk_vaddr  (lk_vaddr),
    .flush     (flush),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_wprot (rsp_wprot),
    .rsp_paddr (rsp_paddr)
);

// File: tb/tb_xlat_tlb.sv
module tb_xlat_tlb;
    import tlb_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic             lk_valid = 0, lk_write = 0, fill_en = 0, fill_wr_ok = 0, flush = 0;
    logic [31:0]      lk_vaddr = 0;
    logic [19:0]      fill_vpn = 0;
    logic [17:0]      fill_ppn = 0;
    logic             rsp_hit, rsp_miss, rsp_wprot;
    logic [29:0]      rsp_paddr;

    xlat_tlb dut (.*);

    int checks = 0, fails = 0;

    // Reference state built from the requirements
    bit        m_vld [16][4];
    bit [15:0] m_tag [16][4];
    bit [17:0] m_ppn [16][4];
    bit        m_wr  [16][4];
    bit [2:0]  m_plru[16];

    bit e_hit, e_miss, e_wp;
    bit [29:0] e_pa;

    function automatic bit [1:0] victim(bit [2:0] p);
        if (p[0]) return p[2] ? 2'd3 : 2'd2;
        return p[1] ? 2'd1 : 2'd0;
    endfunction

    function automatic bit [2:0] touch(bit [2:0] p, bit [1:0] w);
        bit [2:0] r = p;
        if (w < 2) begin r[0] = 1; r[1] = (w == 0); end
        else       begin r[0] = 0; r[2] = (w == 2); end
        return r;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < 16; s++) begin
            m_plru[s] = 0;
            for (int w = 0; w < 4; w++) m_vld[s][w] = 0;
        end
    endtask

    task automatic check(string req, bit [32:0] act, bit [32:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, update model, compare at next negedge.
    task automatic step(bit lv, bit [31:0] va, bit lw, bit fe, bit [19:0] fv,
                        bit [17:0] fp, bit fw, bit fl, string req);
        int s, ms, fs, fw_way, mw;
        bit [15:0] t, ft;
        bit match, fdo;
        lk_valid = lv; lk_vaddr = va; lk_write = lw;
        fill_en = fe; fill_vpn = fv; fill_ppn = fp; fill_wr_ok = fw; flush = fl;
        s = va[15:12]; t = va[31:16];
        match = 0; mw = 0;
        for (int w = 3; w >= 0; w--)
            if (m_vld[s][w] && m_tag[s][w] == t) begin match = 1; mw = w; end
        e_hit  = lv && match && (!lw || m_wr[s][mw]);
        e_wp   = lv && match && lw && !m_wr[s][mw];
        e_miss = lv && !match;
        e_pa   = e_hit ? {m_ppn[s][mw], va[11:0]} : 30'd0;
        // model update
        fdo = fe && !fl;
        fs = fv[3:0]; ft = fv[19:4];
        fw_way = -1;
        for (int w = 3; w >= 0; w--)
            if (m_vld[fs][w] && m_tag[fs][w] == ft) fw_way = w;
        if (fw_way < 0) begin
            for (int w = 3; w >= 0; w--) if (!m_vld[fs][w]) fw_way = w;
        end
        if (fw_way < 0) fw_way = victim(m_plru[fs]);
        ms = s;
        if (fdo) m_plru[fs] = touch(m_plru[fs], 2'(fw_way));
        if (lv && match && !(fdo && fs == ms)) m_plru[ms] = touch(m_plru[ms], 2'(mw));
        if (fl) begin
            for (int a = 0; a < 16; a++) for (int b = 0; b < 4; b++) m_vld[a][b] = 0;
        end else if (fdo) begin
            m_vld[fs][fw_way] = 1; m_tag[fs][fw_way] = ft;
            m_ppn[fs][fw_way] = fp; m_wr[fs][fw_way] = fw;
        end
        @(posedge clk);
        @(negedge clk);
        check(req, {rsp_hit, rsp_miss, rsp_wprot, rsp_paddr}, {e_hit, e_miss, e_wp, e_pa});
    endtask

    task automatic look(bit [19:0] vpn, bit [11:0] off, bit wr, string req);
        step(1, {vpn, off}, wr, 0, 0, 0, 0, 0, req);
    endtask

    task automatic fill(bit [19:0] vpn, bit [17:0] ppn, bit wr);
        step(0, 0, 0, 1, vpn, ppn, wr, 0, "R6");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R10 reset state
        check("R10", {rsp_hit, rsp_miss, rsp_wprot, rsp_paddr}, 33'd0);
        look(20'h12345, 12'h678, 0, "R10");
        // R1 basic translation
        fill(20'hABCD1, 18'h2BEEF, 1);
        look(20'hABCD1, 12'h5A5, 0, "R1");
        look(20'hABCD1, 12'hFFF, 1, "R1");
        // R3 protection
        fill(20'h00072, 18'h01111, 0);
        look(20'h00072, 12'h010, 1, "R3");
        look(20'h00072, 12'h010, 0, "R3");
        // R5 same set, other tag
        look(20'h10072, 12'h000, 0, "R5");
        // R6 overwrite existing tag with new permissions
        fill(20'h00072, 18'h03333, 1);
        look(20'h00072, 12'h444, 1, "R6");
        // R7 eviction order in set 3
        fill(20'h00013, 18'h0000A, 1);
        fill(20'h00023, 18'h0000B, 1);
        fill(20'h00033, 18'h0000C, 1);
        fill(20'h00043, 18'h0000D, 1);
        look(20'h00013, 12'h001, 0, "R7");
        look(20'h00033, 12'h002, 0, "R7");
        fill(20'h00053, 18'h0000E, 1);
        look(20'h00023, 12'h003, 0, "R7");
        check("R7", {31'd0, rsp_miss, rsp_hit}, {31'd0, 2'b10});
        look(20'h00013, 12'h004, 0, "R7");
        look(20'h00043, 12'h005, 0, "R7");
        look(20'h00053, 12'h006, 0, "R7");
        // R9 lookup concurrent with refill of the same page
        step(1, {20'h7777F, 12'h0}, 0, 1, 20'h7777F, 18'h00777, 1, 0, "R9");
        look(20'h7777F, 12'h001, 0, "R9");
        // R8 flush with concurrent refill and lookup
        step(1, {20'hABCD1, 12'h0}, 0, 1, 20'h55550, 18'h00555, 1, 1, "R8");
        look(20'hABCD1, 12'h0, 0, "R8");
        look(20'h55550, 12'h0, 0, "R8");
        // Random mix over a small page pool (R1-style mix, model checked)
        for (int i = 0; i < 4000; i++) begin
            bit [19:0] v, fv;
            int r;
            v  = {16'($urandom_range(0, 5)), 4'($urandom_range(0, 3))};
            fv = {16'($urandom_range(0, 5)), 4'($urandom_range(0, 3))};
            r = $urandom_range(0, 99);
            step($urandom_range(0, 3) != 0, {v, 12'($urandom)}, 1'($urandom),
                 r < 30, fv, 18'($urandom), 1'($urandom), r == 99, "R4");
        end
        look(20'h0, 12'h0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R4");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule